// File: doc/BRIEF.md
# Wait-State Generator for a Slow Read Device

This block stretches read accesses to one slow peripheral by a fixed, selectable number of wait states, from none up to seven. It watches three things from the bus side: a level that marks the first state of every bus cycle, the select line of the slow device, and the active-low read strobe. From these it produces a ready request, which goes to the ready conditioner that sits in front of the processor. That conditioner handles synchronisation, so this block does not. A static three-bit wait-count input takes the place of a board jumper.

The only storage is a chain of flip-flops that acts as a shift register. On every clock edge where the first-state marker is high, the chain is cleared to all zeros. On every other edge it moves one place, and a constant one enters at the head. After a clear, the stages therefore turn high one clock apart, in order. The wait-count input picks which stage is looked at. Count zero picks a constant one, so no wait is added.

The ready request is the selected stage ORed with the gated read strobe. The gated strobe is high when there is no read or when the slow device is not selected. As a result, ready is only held low while a read to the slow device is under way and the selected stage has not yet filled.

The block has no state machine. The state of the chain runs through three conditions. It is cleared on a first-state edge. It is filling while fewer stages are one than it has. It is full once every stage is one, and it stays full until the next first-state edge.

Top module: `wait_state_gen`

## Requirements
- R1: When reset (`rst_n` low) is released, every stage of the chain is zero. A read to the selected device with `wait_sel` = 2 and no first-state edge then shows `rdy_req` low for two clocks, then high.
- R2: Any clock edge with `t1_phase` high clears the whole chain, including when it is partly or fully filled.
- R3: After a clear, one more stage becomes one on each clock edge without `t1_phase`. Stage 0 fills first and the last stage fills last.
- R4: For a read to the selected device, let k be the number of edges since the clear. `rdy_req` is high exactly when `wait_sel` = 0 or k ≥ `wait_sel`.
- R5: While `rd_n` is high (no read), `rdy_req` is high whatever the chain holds.
- R6: While `dev_sel` is low, `rdy_req` is high whatever `rd_n` and the chain hold.
- R7: Once `rdy_req` is high during a read with a steady `wait_sel`, it stays high until the next `t1_phase` edge.
- R8: A bus cycle is T1, then T2, then waits, then T3 and T4. Ready is sampled at the end of T2 and at the end of each wait. Such a cycle to the selected device gets exactly `wait_sel` wait states. A cycle to any other device gets none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; clears the chain |
| t1_phase | input | 1 | High during the first state of every bus cycle |
| dev_sel | input | 1 | High when the slow device is addressed |
| rd_n | input | 1 | Active-low read strobe |
| wait_sel | input | 3 | Number of wait states to insert (0 to 7) |
| rdy_req | output | 1 | Ready request to the ready conditioner |

## Verification
Full bus cycles are run for each of the eight wait counts with the device selected. This shows whether every tap is wired to the right stage: an off-by-one in the chain or in the mux changes the wait count it gives. The same cycles run with the device deselected confirm that the gating, not the chain, keeps ready high. Directed patterns cover the rest. One lifts the strobe in the middle of a fill, which separates the strobe term from the tap term. Another issues a first-state edge on a chain that is partly filled. A third holds a read for many clocks after ready rises, which shows whether ready stays high.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    // Number of stages in the fill chain; the wait count reaches DEPTH-1.
    localparam int FILL_DEPTH = 8;
    localparam int SEL_W      = $clog2(FILL_DEPTH);
endpackage

// File: rtl/wsg_fill_chain.sv
module wsg_fill_chain #(
    parameter int DEPTH = wsg_pkg::FILL_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [DEPTH-1:0] stages
);
    // Each stage copies its predecessor; stage 0 takes a constant one.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic nxt;
        if (g == 0) begin : g_head
            assign nxt = 1'b1;
        end else begin : g_body
            assign nxt = stages[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   stages[g] <= 1'b0;
            else if (clr) stages[g] <= 1'b0;
            else          stages[g] <= nxt;
        end
    end
endmodule

// File: rtl/wsg_tap_select.sv
module wsg_tap_select #(
    parameter int DEPTH = wsg_pkg::FILL_DEPTH,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] stages,
    input  logic [SW-1:0]    sel,
    output logic             tap
);
    // Tap 0 is a constant one (no wait); tap k watches stage k-1.
    logic [DEPTH-1:0] taps;
    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        if (g == 0) begin : g_zero
            assign taps[g] = 1'b1;
        end else begin : g_stage
            assign taps[g] = stages[g-1];
        end
    end
    assign tap = taps[sel];
    // The last stage only matters for width symmetry.
    logic unused_last;
    assign unused_last = stages[DEPTH-1];
endmodule

// File: rtl/wsg_strobe_gate.sv
module wsg_strobe_gate (
    input  logic dev_sel,
    input  logic rd_n,
    input  logic tap,
    output logic rdy
);
    logic slow_rd_n;
    always_comb begin
        slow_rd_n = rd_n | ~dev_sel;
        rdy       = tap | slow_rd_n;
    end
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
    parameter int DEPTH = wsg_pkg::FILL_DEPTH,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t1_phase,
    input  logic          dev_sel,
    input  logic          rd_n,
    input  logic [SW-1:0] wait_sel,
    output logic          rdy_req
);
    logic [DEPTH-1:0] stages;
    logic             tap;

    wsg_fill_chain #(.DEPTH(DEPTH)) chain_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (t1_phase),
        .stages (stages)
    );

    wsg_tap_select #(.DEPTH(DEPTH)) mux_i (
        .stages (stages),
        .sel    (wait_sel),
        .tap    (tap)
    );

    wsg_strobe_gate gate_i (
        .dev_sel (dev_sel),
        .rd_n    (rd_n),
        .tap     (tap),
        .rdy     (rdy_req)
    );
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
    parameter int DEPTH = wsg_pkg::FILL_DEPTH,
    localparam int SW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          t1_phase,
    input logic          dev_sel,
    input logic          rd_n,
    input logic [SW-1:0] wait_sel,
    input logic          rdy_req
);
    // Independent count of edges since the last clear, saturating.
    logic [CW-1:0] since_clr;
    logic          primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_clr <= '0;
            primed    <= 1'b0;
        end else begin
            primed <= 1'b1;
            if (t1_phase)                        since_clr <= '0;
            else if (since_clr != CW'(DEPTH))    since_clr <= since_clr + 1'b1;
        end
    end

    logic slow_read;
    assign slow_read = !rd_n && dev_sel;

    // R2
    clear_on_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t1_phase |=> (!slow_read || wait_sel == '0 || !rdy_req));

    // R4
    wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_read |-> (rdy_req == (wait_sel == '0 || since_clr >= CW'(wait_sel))));

    // R5
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> rdy_req);

    // R6
    other_dev_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_sel |-> rdy_req);

    // R7
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && slow_read && $past(slow_read) && $past(rdy_req)
         && !$past(t1_phase) && $stable(wait_sel)) |-> rdy_req);
endmodule

bind wait_state_gen wsg_checker #(.DEPTH(DEPTH)) wsg_chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .t1_phase (t1_phase),
    .dev_sel  (dev_sel),
    .rd_n     (rd_n),
    .wait_sel (wait_sel),
    .rdy_req  (rdy_req)
);

// File: tb/wait_state_gen_tb_top.sv
module wait_state_gen_tb_top;
    localparam int PERIOD = 10;
    localparam int NVEC   = 10;
    // Vector: {dev_sel, wait_sel[2:0], expected waits[3:0]}
    localparam logic [7:0] VECS [NVEC] = '{
        {1'b1, 3'd0, 4'd0}, {1'b1, 3'd1, 4'd1}, {1'b1, 3'd2, 4'd2},
        {1'b1, 3'd3, 4'd3}, {1'b1, 3'd4, 4'd4}, {1'b1, 3'd5, 4'd5},
        {1'b1, 3'd6, 4'd6}, {1'b1, 3'd7, 4'd7}, {1'b0, 3'd5, 4'd0},
        {1'b0, 3'd7, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t1_phase = 1'b0;
    logic       dev_sel = 1'b0;
    logic       rd_n = 1'b1;
    logic [2:0] wait_sel = 3'd0;
    logic       rdy_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    wait_state_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .t1_phase (t1_phase),
        .dev_sel  (dev_sel),
        .rd_n     (rd_n),
        .wait_sel (wait_sel),
        .rdy_req  (rdy_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One bus cycle: T1, T2, waits while ready is low, T3, T4.
    task automatic bus_cycle(input logic [2:0] sel, input logic dev, output int waits);
        @(negedge clk); t1_phase = 1'b1; rd_n = 1'b1; wait_sel = sel; dev_sel = dev;
        @(negedge clk); t1_phase = 1'b0; rd_n = 1'b0;
        #1;
        waits = 0;
        while (!rdy_req && waits < 20) begin
            waits++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        @(negedge clk); rd_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1: reset state, idle bus gives ready
        #1 chk("R1 idle after reset", int'(rdy_req), 1);
        rst_n = 1'b1;
        // R1/R3: chain is empty out of reset; read with sel 2, no T1
        @(negedge clk); dev_sel = 1'b1; wait_sel = 3'd2; rd_n = 1'b0;
        #1 chk("R1 chain empty", int'(rdy_req), 0);
        // first reset-released edge already passed before this negedge
        @(negedge clk); #1 chk("R3 two stages filled", int'(rdy_req), 1);
        rd_n = 1'b1;

        // Table walk: R8 and R4/R6 through full bus cycles
        for (int i = 0; i < NVEC; i++) begin
            bus_cycle(VECS[i][6:4], VECS[i][7], w);
            chk(VECS[i][7] ? "R8 waits equal select" : "R6 other device no wait",
                w, int'(VECS[i][3:0]));
        end

        // R5: strobe lifted mid-fill forces ready
        @(negedge clk); t1_phase = 1'b1; dev_sel = 1'b1; wait_sel = 3'd6; rd_n = 1'b0;
        @(negedge clk); t1_phase = 1'b0;
        #1 chk("R4 not filled", int'(rdy_req), 0);
        rd_n = 1'b1; #1 chk("R5 no read gives ready", int'(rdy_req), 1);
        rd_n = 1'b0; dev_sel = 1'b0; #1 chk("R6 deselected gives ready", int'(rdy_req), 1);
        dev_sel = 1'b1;

        // R2: T1 on a partly filled chain restarts the count
        repeat (3) @(negedge clk);
        wait_sel = 3'd2; #1 chk("R3 partly filled", int'(rdy_req), 1);
        t1_phase = 1'b1;
        @(negedge clk); t1_phase = 1'b0;
        #1 chk("R2 cleared by T1", int'(rdy_req), 0);
        @(negedge clk); #1 chk("R3 one stage only", int'(rdy_req), 0);
        @(negedge clk); #1 chk("R4 two stages reach sel 2", int'(rdy_req), 1);

        // R7: ready stays high through a long held read
        wait_sel = 3'd7;
        repeat (6) @(negedge clk);
        #1 chk("R4 full chain for sel 7", int'(rdy_req), 1);
        begin
            int lows = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk); #1;
                if (!rdy_req) lows++;
            end
            chk("R7 ready holds", lows, 0);
        end
        rd_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule